// File: doc/BRIEF.md
# Edge-to-Edge Time-Out Checker

This block measures how long a single event line stays in one level and raises an interrupt flag when that interval runs longer than a programmed limit. An edge of the chosen polarity on the event line clears a 16-bit counter and starts it. The opposite edge stops the counter and leaves it frozen, so the measured interval can be read from the count output. If the count reaches the limit while the measurement is still open, a sticky flag is set. Software clears the flag by writing one.

The event line is asynchronous. It passes through a synchronizer, and an edge is found by comparing the synchronized level with its value one clock earlier. A polarity select decides which edge opens an interval and which edge closes it. An enable gates whether edges are acted on at all. A count-enable input acts as the count clock qualifier. The interrupt request is the flag masked by its enable.

Top module: `eto_timeout_checker`

## Requirements
- R1: With `evt_en`=1 and `edge_sel`=0, a rising edge on `evt_in` while frozen sets `running` to 1 and `count` to 0. Both are visible three clock edges after `evt_in` changes: two synchronizer stages plus the edge register.
- R2: While running with `cnt_en`=1, a falling edge (with `edge_sel`=0) sets `running` to 0. The count then holds D, where D is the number of clock cycles between the two changes of `evt_in`.
- R3: While running, the clock edge that follows a cycle in which `count` equals `limit` sets `flag`. This also holds when that cycle is the one in which the closing edge is taken. No flag is set while frozen.
- R4: While frozen, `count` holds its value. A new opening edge restarts the count from 0.
- R5: While running, the counter wraps from all ones to 0 and keeps counting.
- R6: While running, `count` holds when `cnt_en` is 0 and advances by one per clock when `cnt_en` is 1.
- R7: With `edge_sel`=1, a falling edge opens the interval and a rising edge closes it. A closing edge while frozen has no effect.
- R8: With `evt_en`=0, edges on `evt_in` are ignored. `running` and `count` keep their values.
- R9: A one on `flag_clr` clears `flag` at the next clock edge. If a set and a clear fall on the same cycle, the set wins and `flag` reads 1.
- R10: `irq` equals `flag` AND `irq_en`, combinationally.
- R11: `flag` is set at most once per measurement. After it is cleared, the count wrapping past `limit` again does not set it again.
- R12: After reset, `running`, `count`, `flag` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_in | input | 1 | Asynchronous event line |
| evt_en | input | 1 | Act on edges of the event line |
| edge_sel | input | 1 | 0: rising opens and falling closes; 1: falling opens and rising closes |
| cnt_en | input | 1 | Count-clock qualifier |
| limit | input | 16 | Time-out compare value |
| irq_en | input | 1 | Interrupt request enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| count | output | 16 | Current or frozen count |
| running | output | 1 | 1 while a measurement is open, 0 while frozen |
| flag | output | 1 | Sticky time-out flag |
| irq | output | 1 | Interrupt request |

## Verification
The flag can be set by a limit match and cleared by a software strobe in the same cycle. The bench provokes this by opening an interval with a small limit. It counts clocks until the count equals the limit, then pulses `flag_clr` in exactly that cycle. After the next edge it expects `flag` to read 1, because the set must win. A second overlap, a limit match in the cycle that takes the closing edge, is covered by R3. The bench judges it through the frozen count, which must equal the interval length.

// File: rtl/eto_pkg.sv
// Shared types for the edge-to-edge time-out checker.
// Assumes: nothing beyond a two-state measurement model.
package eto_pkg;
    typedef enum logic {
        ST_FROZEN = 1'b0,
        ST_RUN    = 1'b1
    } eto_state_t;
endpackage

// File: rtl/eto_edge_detect.sv
// Synchronizes the event line and turns its edges into open/close pulses.
// Assumes: SYNC_STAGES >= 2. At most one edge is reported per clock,
// because a level can only change once between two samples.
module eto_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic evt_in,
    input  logic evt_en,
    input  logic edge_sel,
    output logic open_pulse,
    output logic close_pulse
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [LAST:0] sync_q;
    logic          prev_q;
    logic          rise;
    logic          fall;

    // Shift the asynchronous level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[LAST-1:0], evt_in};
        end
    end

    // Remember the synchronized level of the previous clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sync_q[LAST];
        end
    end

    // Classify the edge and map it to open/close by the polarity select.
    always_comb begin
        rise        = sync_q[LAST] & ~prev_q;
        fall        = ~sync_q[LAST] & prev_q;
        open_pulse  = evt_en & (edge_sel ? fall : rise);
        close_pulse = evt_en & (edge_sel ? rise : fall);
    end
endmodule

// File: rtl/eto_run_ctrl.sv
// Run/freeze state machine. Opening pulses always (re)start a measurement;
// a closing pulse ends one that is running.
// Assumes: open and close pulses are never high in the same cycle.
module eto_run_ctrl
    import eto_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic open_pulse,
    input  logic close_pulse,
    output logic running
);
    eto_state_t state_q;
    eto_state_t state_d;

    // Next-state decision.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FROZEN: if (open_pulse)  state_d = ST_RUN;
            ST_RUN:    if (!open_pulse && close_pulse) state_d = ST_FROZEN;
            default:   state_d = ST_FROZEN;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FROZEN;
        end else begin
            state_q <= state_d;
        end
    end

    assign running = (state_q == ST_RUN);
endmodule

// File: rtl/eto_count_cmp.sv
// Interval counter with a once-per-measurement compare against the limit.
// Assumes: the counter wraps naturally at 2**WIDTH. The compare is armed by
// each opening pulse and disarmed by its own first match.
module eto_count_cmp #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_pulse,
    input  logic             running,
    input  logic             cnt_en,
    input  logic [WIDTH-1:0] limit,
    output logic [WIDTH-1:0] count,
    output logic             hit
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] count_q;
    logic             armed_q;

    // Clear on an opening pulse, otherwise advance while running and enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (open_pulse) begin
            count_q <= '0;
        end else if (running && cnt_en) begin
            count_q <= count_q + ONE;
        end
    end

    // Arm the compare per measurement and disarm it after the first match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (open_pulse) begin
            armed_q <= 1'b1;
        end else if (hit) begin
            armed_q <= 1'b0;
        end
    end

    // Match only while a measurement is open and still armed.
    assign hit   = running && armed_q && (count_q == limit);
    assign count = count_q;
endmodule

// File: rtl/eto_flag.sv
// Sticky time-out flag with write-one-to-clear and a masked request.
// Assumes: a set and a clear in the same cycle resolve to set.
module eto_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic flag_clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    logic flag_q;

    // Set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;
    assign irq  = flag_q & irq_en;
endmodule

// File: rtl/eto_timeout_checker.sv
// Top level: measures an edge-to-edge interval on one event line and flags
// intervals that reach the programmed limit before they are closed.
// Assumes: the event line may be asynchronous. Edges are taken after
// SYNC_STAGES synchronizer flops plus one edge register.
module eto_timeout_checker #(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_in,
    input  logic             evt_en,
    input  logic             edge_sel,
    input  logic             cnt_en,
    input  logic [WIDTH-1:0] limit,
    input  logic             irq_en,
    input  logic             flag_clr,
    output logic [WIDTH-1:0] count,
    output logic             running,
    output logic             flag,
    output logic             irq
);
    logic open_pulse;
    logic close_pulse;
    logic hit;

    eto_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_in      (evt_in),
        .evt_en      (evt_en),
        .edge_sel    (edge_sel),
        .open_pulse  (open_pulse),
        .close_pulse (close_pulse)
    );

    eto_run_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .open_pulse  (open_pulse),
        .close_pulse (close_pulse),
        .running     (running)
    );

    eto_count_cmp #(.WIDTH(WIDTH)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .open_pulse (open_pulse),
        .running    (running),
        .cnt_en     (cnt_en),
        .limit      (limit),
        .count      (count),
        .hit        (hit)
    );

    eto_flag u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .hit      (hit),
        .flag_clr (flag_clr),
        .irq_en   (irq_en),
        .flag     (flag),
        .irq      (irq)
    );
endmodule

// File: rtl/eto_timeout_checker_sva.sv
// Property checker for the time-out checker, attached by bind.
// Assumes: synchronous active-low reset on rst_n.
module eto_timeout_checker_sva #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             flag_clr,
    input logic [WIDTH-1:0] count,
    input logic             running,
    input logic             flag
);
    AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(running) |-> (count == '0)); // R1

    AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !$past(running)) |-> $stable(count)); // R4

    AST_RUN_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && $past(cnt_en) && (count != '0))
            |-> (count == $past(count) + WIDTH'(1))); // R6

    AST_RUN_PAUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (running && $past(running) && !$past(cnt_en) && (count != '0))
            |-> $stable(count)); // R6

    AST_FLAG_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(running)); // R3

    AST_FLAG_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(flag_clr)); // R9
endmodule

bind eto_timeout_checker eto_timeout_checker_sva #(.WIDTH(WIDTH)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_en   (cnt_en),
    .flag_clr (flag_clr),
    .count    (count),
    .running  (running),
    .flag     (flag)
);

// File: tb/eto_timeout_checker_tb.sv
`timescale 1ns/1ps
module eto_timeout_checker_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         evt_in, evt_en, edge_sel, cnt_en, irq_en, flag_clr;
    logic [W-1:0] limit;
    logic [W-1:0] count;
    logic         running, flag, irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    eto_timeout_checker #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .evt_en(evt_en),
        .edge_sel(edge_sel), .cnt_en(cnt_en), .limit(limit),
        .irq_en(irq_en), .flag_clr(flag_clr), .count(count),
        .running(running), .flag(flag), .irq(irq)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic pulse_clear();
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12", "running", running, 0);
        chk("R12", "count", count, 0);
        chk("R12", "flag", flag, 0);
        chk("R12", "irq", irq, 0);
    endtask

    task automatic t_basic();
        limit = 16'd10;
        evt_in = 1'b1; step(3);
        chk("R1", "running after open", running, 1);
        chk("R1", "count after open", count, 0);
        step(5);
        chk("R6", "count while running", count, 5);
        evt_in = 1'b0; step(3);
        chk("R2", "running after close", running, 0);
        chk("R2", "interval length", count, 8);
        chk("R3", "no flag below limit", flag, 0);
        step(4);
        chk("R4", "frozen count holds", count, 8);
    endtask

    task automatic t_timeout();
        limit = 16'd4;
        evt_in = 1'b1; step(3);
        step(4);
        chk("R3", "flag not yet at match cycle", flag, 0);
        step(1);
        chk("R3", "flag after match", flag, 1);
        chk("R10", "irq with enable", irq, 1);
        irq_en = 1'b0; #1;
        chk("R10", "irq masked", irq, 0);
        irq_en = 1'b1;
        evt_in = 1'b0; step(3);
        chk("R2", "count after late close", count, 8);
        chk("R9", "flag sticky after close", flag, 1);
        pulse_clear();
        chk("R9", "flag cleared by write", flag, 0);
        chk("R10", "irq follows cleared flag", irq, 0);
    endtask

    task automatic t_restart();
        limit = 16'd1000;
        evt_in = 1'b1; step(3);
        chk("R4", "restart from zero", count, 0);
        step(2);
        evt_in = 1'b0; step(3);
        chk("R4", "second interval", count, 5);
    endtask

    task automatic t_cnten();
        evt_in = 1'b1; step(3);
        step(3);
        cnt_en = 1'b0; step(5);
        chk("R6", "count paused", count, 3);
        chk("R6", "still running when paused", running, 1);
        cnt_en = 1'b1; step(2);
        chk("R6", "count resumed", count, 5);
        evt_in = 1'b0; step(3);
        chk("R2", "frozen after paused run", count, 8);
    endtask

    task automatic t_edgesel();
        edge_sel = 1'b1;
        evt_in = 1'b1; step(3);
        chk("R7", "rising is close when frozen", running, 0);
        chk("R7", "count untouched", count, 8);
        evt_in = 1'b0; step(3);
        chk("R7", "falling opens", running, 1);
        chk("R7", "falling clears count", count, 0);
        step(2);
        evt_in = 1'b1; step(3);
        chk("R7", "rising closes", running, 0);
        chk("R7", "inverted interval", count, 5);
        edge_sel = 1'b0;
        evt_in = 1'b0; step(3);
    endtask

    task automatic t_evten();
        evt_en = 1'b0;
        evt_in = 1'b1; step(3);
        chk("R8", "edge ignored running", running, 0);
        chk("R8", "edge ignored count", count, 5);
        evt_in = 1'b0; step(3);
        evt_en = 1'b1;
    endtask

    task automatic t_coincide();
        limit = 16'd3;
        evt_in = 1'b1; step(3);
        step(3);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        chk("R9", "set wins over clear", flag, 1);
        evt_in = 1'b0; step(3);
        chk("R2", "interval after coincidence", count, 7);
        pulse_clear();
    endtask

    task automatic t_wrap_once();
        limit = 16'd2;
        evt_in = 1'b1; step(3);
        step(3);
        chk("R3", "flag for small limit", flag, 1);
        pulse_clear();
        chk("R9", "flag cleared mid-run", flag, 0);
        step(65532);
        chk("R5", "count wrapped to zero", count, 0);
        chk("R5", "still running at wrap", running, 1);
        step(4);
        chk("R11", "no second flag after wrap", flag, 0);
        chk("R5", "count after wrap", count, 4);
        evt_in = 1'b0; step(3);
    endtask

    initial begin
        rst_n = 1'b0; evt_in = 1'b0; evt_en = 1'b1; edge_sel = 1'b0;
        cnt_en = 1'b1; irq_en = 1'b1; flag_clr = 1'b0; limit = '0;
        step(4);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_basic();
        t_timeout();
        t_restart();
        t_cnten();
        t_edgesel();
        t_evten();
        t_coincide();
        t_wrap_once();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule